// File: doc/BRIEF.md
# CPU Standby Mode Sequencer

This block decides when a small processor core sleeps and how it wakes up. The core raises a one-cycle request when it executes its wait or stop instruction. The sequencer then halts the core. It gates the peripheral clocks and stops the oscillator when the chosen mode calls for that. It watches the interrupt lines for a wake source and then releases everything. After a deep sleep it first waits out a fixed oscillator settle time.

On every wake-up it gives the core a single-cycle pulse and a flag. The flag tells the core whether to take the interrupt or just continue with the next instruction. That choice follows the X mask for the non-maskable line and the I mask for the maskable sources. The S bit can turn a stop request into a no-operation. A synchronous reset sends the sequencer back to the running state from any sleep state.

Top module: `stby_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, outputs read running: `cpu_halt`=0, `periph_clk_en`=1, `osc_en`=1, `wake_pulse`=0, `wake_service`=0.
- R2: A `wai_req` in the running state gives, after the next edge, `cpu_halt`=1 with `periph_clk_en`=1 and `osc_en`=1.
- R3: In light sleep, a high `irq_in`, `xirq` or `int_req` returns the core to running after the next edge, with `wake_pulse` high for exactly one cycle.
- R4: A `stop_req` in the running state with `s_bit`=0 gives, after the next edge, `cpu_halt`=1, `periph_clk_en`=0 and `osc_en`=0. It wins over a `wai_req` in the same cycle.
- R5: With `s_bit`=1 a `stop_req` is ignored. Outputs stay running, or go to light sleep if `wai_req` is also high.
- R6: In deep sleep only `xirq` or a rising edge of `irq_in` (0 in the previous cycle, 1 now) wakes the block. `int_req` and a steadily high `irq_in` do not.
- R7: After a deep-sleep wake edge, `osc_en`=1 while `cpu_halt`=1 and `periph_clk_en`=0 for SETTLE_CYC cycles (default 16). After that the outputs read running and `wake_pulse` is high for one cycle.
- R8: `wake_service`=1 when a wake comes from `xirq` with `x_bit`=0, or from a maskable source with `i_bit`=0. Otherwise it is 0. The masks are sampled in the cycle of the wake event.
- R9: A reset in light sleep, deep sleep or settle returns to running after the next edge with no `wake_pulse`. This holds even when a wake source is active in the same cycle.
- R10: `wake_service` is high only together with `wake_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wai_req | input | 1 | Light-sleep request from the core |
| stop_req | input | 1 | Deep-sleep request from the core |
| irq_in | input | 1 | External maskable interrupt, active high |
| xirq | input | 1 | Non-maskable external interrupt, active high |
| int_req | input | 1 | Any internal peripheral interrupt |
| s_bit | input | 1 | Stop-disable mask |
| x_bit | input | 1 | Non-maskable interrupt mask |
| i_bit | input | 1 | Maskable interrupt mask |
| cpu_halt | output | 1 | Core halted |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle wake-up indication |
| wake_service | output | 1 | 1 = take the interrupt, 0 = resume |

## Verification
Two functions can fall in the same cycle: the reset path and a wake exit. The bench provokes this by raising reset in the very cycle an interrupt arrives in light sleep, and in the cycle `xirq` arrives in deep sleep. It also raises reset in the middle of the settle count. A correct result is running outputs with no wake pulse, either at once or one cycle later. A second collision is a stop request together with a wait request under each value of the S bit. It is judged by which sleep state the outputs show.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_LIGHT  = 2'd1,
    ST_DEEP   = 2'd2,
    ST_SETTLE = 2'd3
  } stby_state_e;
endpackage

// File: rtl/stby_wake_eval.sv
module stby_wake_eval (
  input  logic clk,
  input  logic rst,
  input  logic in_deep,
  input  logic irq_in,
  input  logic xirq,
  input  logic int_req,
  input  logic x_bit,
  input  logic i_bit,
  output logic wake,
  output logic service
);
  logic irq_q;
  logic irq_rise;
  logic mask_src;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_in;
  end

  assign irq_rise = irq_in & ~irq_q;

  // Deep sleep accepts only the IRQ edge; light sleep accepts levels and internal sources.
  always_comb begin
    mask_src = in_deep ? irq_rise : (irq_in | int_req);
    wake     = xirq | mask_src;
    service  = (xirq & ~x_bit) | (mask_src & ~i_bit);
  end

  assert_service_needs_wake_R8: assert property (@(posedge clk) disable iff (rst)
    service |-> wake);
endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = active && (cnt == LAST);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_cnt_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0));
endmodule

// File: rtl/stby_seq.sv
module stby_seq #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic wai_req,
  input  logic stop_req,
  input  logic irq_in,
  input  logic xirq,
  input  logic int_req,
  input  logic s_bit,
  input  logic x_bit,
  input  logic i_bit,
  output logic cpu_halt,
  output logic periph_clk_en,
  output logic osc_en,
  output logic wake_pulse,
  output logic wake_service
);
  import stby_pkg::*;

  stby_state_e state, nxt;
  logic wake, svc_now, settle_done;
  logic svc_hold, hold_ld;
  logic pulse_n, svc_n;

  stby_wake_eval u_wake (
    .clk     (clk),
    .rst     (rst),
    .in_deep (state == ST_DEEP),
    .irq_in  (irq_in),
    .xirq    (xirq),
    .int_req (int_req),
    .x_bit   (x_bit),
    .i_bit   (i_bit),
    .wake    (wake),
    .service (svc_now)
  );

  stby_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .active (state == ST_SETTLE),
    .done   (settle_done)
  );

  always_comb begin
    nxt     = state;
    pulse_n = 1'b0;
    svc_n   = 1'b0;
    hold_ld = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (stop_req && !s_bit) nxt = ST_DEEP;
        else if (wai_req)       nxt = ST_LIGHT;
      end
      ST_LIGHT: begin
        if (wake) begin
          nxt     = ST_RUN;
          pulse_n = 1'b1;
          svc_n   = svc_now;
        end
      end
      ST_DEEP: begin
        if (wake) begin
          nxt     = ST_SETTLE;
          hold_ld = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_done) begin
          nxt     = ST_RUN;
          pulse_n = 1'b1;
          svc_n   = svc_hold;
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_RUN;
      cpu_halt      <= 1'b0;
      periph_clk_en <= 1'b1;
      osc_en        <= 1'b1;
      wake_pulse    <= 1'b0;
      wake_service  <= 1'b0;
      svc_hold      <= 1'b0;
    end else begin
      state         <= nxt;
      cpu_halt      <= (nxt != ST_RUN);
      periph_clk_en <= (nxt == ST_RUN) || (nxt == ST_LIGHT);
      osc_en        <= (nxt != ST_DEEP);
      wake_pulse    <= pulse_n;
      wake_service  <= svc_n;
      if (hold_ld) svc_hold <= svc_now;
    end
  end

  assert_gated_means_halted_R4: assert property (@(posedge clk) disable iff (rst)
    !periph_clk_en |-> cpu_halt);
  assert_osc_off_gates_clk_R7: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !periph_clk_en);
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  assert_service_with_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    wake_service |-> wake_pulse);
  assert_stop_nop_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && stop_req && s_bit && !wai_req) |=> !cpu_halt);
  assert_stop_enter_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && stop_req && !s_bit) |=> (!osc_en && cpu_halt));
  assert_reset_run_R9: assert property (@(posedge clk)
    rst |=> (!cpu_halt && periph_clk_en && osc_en && !wake_pulse));
endmodule

// File: tb/tb_stby_seq.sv
module tb_stby_seq;
  localparam int SETTLE_CYC = 16;
  localparam logic [4:0] RUNO  = 5'b01100;
  localparam logic [4:0] LITO  = 5'b11100;
  localparam logic [4:0] DEEPO = 5'b10000;
  localparam logic [4:0] SETO  = 5'b10100;
  localparam logic [4:0] WK1   = 5'b01111;
  localparam logic [4:0] WK0   = 5'b01110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wai_req = 0, stop_req = 0, irq_in = 0, xirq = 0, int_req = 0;
  logic s_bit = 0, x_bit = 0, i_bit = 0;
  logic cpu_halt, periph_clk_en, osc_en, wake_pulse, wake_service;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         at;
    logic [4:0] val;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stby_seq #(.SETTLE_CYC(SETTLE_CYC)) dut (
    .clk(clk), .rst(rst), .wai_req(wai_req), .stop_req(stop_req),
    .irq_in(irq_in), .xirq(xirq), .int_req(int_req),
    .s_bit(s_bit), .x_bit(x_bit), .i_bit(i_bit),
    .cpu_halt(cpu_halt), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .wake_pulse(wake_pulse), .wake_service(wake_service)
  );

  // Driver: apply one cycle of inputs and queue the outputs expected after the next edge.
  task automatic drv(input logic r, input logic w, input logic st, input logic iq,
                     input logic xq, input logic it, input logic s, input logic x,
                     input logic i, input logic [4:0] e, input string tag);
    exp_t item;
    @(negedge clk);
    rst = r; wai_req = w; stop_req = st; irq_in = iq; xirq = xq; int_req = it;
    s_bit = s; x_bit = x; i_bit = i;
    item.at = cyc + 1; item.val = e; item.tag = tag;
    q.push_back(item);
  endtask

  // Monitor: compare in the middle of the high phase.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0 && q[0].at == cyc) begin
        exp_t item;
        logic [4:0] act;
        item = q.pop_front();
        act = {cpu_halt, periph_clk_en, osc_en, wake_pulse, wake_service};
        checks++;
        if (act !== item.val) begin
          errors++;
          $display("FAIL %s cycle %0d: got %b expected %b (halt,pclk,osc,pulse,svc)",
                   item.tag, cyc, act, item.val);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    drv(1,0,0,0,0,0,0,0,0, RUNO, "R1");
    drv(1,0,0,0,0,0,0,0,0, RUNO, "R1");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R1");
    // R2 / R3 light sleep, IRQ wake served
    drv(0,1,0,0,0,0,0,0,0, LITO, "R2");
    drv(0,0,0,0,0,0,0,0,0, LITO, "R2");
    drv(0,0,0,1,0,0,0,0,0, WK1,  "R3 R8");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R10");
    // internal source with I set: resume only
    drv(0,1,0,0,0,0,0,0,1, LITO, "R2");
    drv(0,0,0,0,0,1,0,0,1, WK0,  "R3 R8");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R10");
    // XIRQ with X set, then X clear
    drv(0,1,0,0,0,0,0,1,0, LITO, "R2");
    drv(0,0,0,0,1,0,0,1,0, WK0,  "R8");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R3");
    drv(0,1,0,0,0,0,0,0,1, LITO, "R2");
    drv(0,0,0,0,1,0,0,0,1, WK1,  "R8");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R10");
    // R5 S bit turns stop into nothing
    drv(0,0,1,0,0,0,1,0,0, RUNO, "R5");
    drv(0,1,1,0,0,0,1,0,0, LITO, "R5");
    drv(0,0,0,0,0,1,1,0,0, WK1,  "R3");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R3");
    // R4 / R6 / R7 deep sleep, IRQ held high beforehand
    drv(0,0,0,1,0,0,0,0,0, RUNO, "R6");
    drv(0,1,1,1,0,0,0,0,0, DEEPO,"R4");
    drv(0,0,0,1,0,1,0,0,0, DEEPO,"R6");
    drv(0,0,0,0,0,0,0,0,0, DEEPO,"R6");
    drv(0,0,0,1,0,0,0,0,0, SETO, "R7");
    for (int k = 0; k < SETTLE_CYC - 1; k++)
      drv(0,0,0,1,0,0,0,0,1, SETO, "R7");
    drv(0,0,0,0,0,0,0,0,1, WK1,  "R7 R8");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R10");
    // XIRQ ends deep sleep with X set: resume only
    drv(0,0,1,0,0,0,0,1,0, DEEPO,"R4");
    drv(0,0,0,0,1,0,0,1,0, SETO, "R6");
    for (int k = 0; k < SETTLE_CYC - 1; k++)
      drv(0,0,0,0,0,0,0,0,0, SETO, "R7");
    drv(0,0,0,0,0,0,0,0,0, WK0,  "R6 R8");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R10");
    // R9 reset collides with wake
    drv(0,1,0,0,0,0,0,0,0, LITO, "R9");
    drv(1,0,0,1,0,0,0,0,0, RUNO, "R9");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R9");
    drv(0,0,1,0,0,0,0,0,0, DEEPO,"R9");
    drv(1,0,0,0,1,0,0,0,0, RUNO, "R9");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R9");
    drv(0,0,1,0,0,0,0,0,0, DEEPO,"R9");
    drv(0,0,0,0,1,0,0,0,0, SETO, "R9");
    drv(0,0,0,0,0,0,0,0,0, SETO, "R9");
    drv(1,0,0,0,0,0,0,0,0, RUNO, "R9");
    drv(0,0,0,0,0,0,0,0,0, RUNO, "R9");
    for (int k = 0; k < SETTLE_CYC; k++)
      drv(0,0,0,0,0,0,0,0,0, RUNO, "R9");
    repeat (3) @(posedge clk);
    #6;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule